// File: doc/BRIEF.md
# Floating-Point Operand Screening Stage

This stage looks at one 64-bit IEEE double-precision operand before a floating-point instruction runs and decides whether that operand must raise an arithmetic trap. The decision depends on a mode chosen for each operand:

- **Plain arithmetic.** Denormals, infinities and NaNs are rejected.
- **Comparison.** Infinities are let through.
- **Software-assisted completion.** Only denormals are rejected, and only while input flushing to zero is off.

The verdict has four flags, each a separate output:

- a trap request;
- an invalid-operation exception bit;
- a software-completion exception bit;
- a one-cycle request to set the sticky invalid status bit.

Operands arrive on a valid/ready input. Verdicts leave through a single register stage with a valid/ready output. The input is ready whenever the output register is empty or is being drained in the same cycle. While `out_ready` is low with a verdict held, that verdict and `out_valid` stay frozen and `in_ready` is low. Any operand offered during that time is not taken. An operand is accepted on a rising clock edge where `in_valid` and `in_ready` are both high, and its verdict appears on the outputs after that edge. When no verdict is held, all four flags are low. The mode and flush control are sampled together with the operand.

Top module: `fpchk_top`

## Requirements
- R1: The exponent is bits 62:52 and the fraction is bits 51:0. In plain mode (`in_mode`=0), an operand with exponent 0 and a nonzero fraction gives trap=1, inv=1, swc=0, sticky=0.
- R2: In plain mode, an operand with exponent 0x7FF (infinity or NaN) gives trap=1, inv=1, swc=0, sticky=1.
- R3: In compare mode (`in_mode`=1), an operand with exponent 0x7FF and fraction 0 (infinity) gives no trap and all flags 0. A NaN gives trap=1, inv=1, sticky=1, swc=0. A denormal gives the same result as in R1.
- R4: In software-completion mode (`in_mode`=2) with `in_flush`=0, an operand whose magnitude (sign bit cleared) lies in 1..0x000FFFFFFFFFFFFF traps with trap=1, inv=1, swc=1, sticky=0. This holds for either sign.
- R5: In software-completion mode with `in_flush`=1, no operand traps. In software-completion mode, infinities and NaNs never trap, whatever the value of `in_flush`.
- R6: Positive and negative zero, and operands with an exponent in 1..0x7FE, never trap in any mode; all four flags are 0.
- R7: Mode encoding 3 gives exactly the result of plain mode.
- R8: An operand accepted at a rising edge has its verdict on the outputs, with `out_valid`=1, right after that edge. With `out_ready`=1 and no new operand, `out_valid` returns to 0 after the next edge. Whenever `out_valid`=0, all four flags are 0.
- R9: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and the held verdict does not change. The first operand offered after `out_ready` returns to 1 is the next one accepted.
- R10: `in_flush` has no effect in plain and compare modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Stage can take an operand |
| in_data | input | 64 | Double-precision operand |
| in_mode | input | 2 | 0 plain, 1 compare, 2 software completion, 3 plain |
| in_flush | input | 1 | Input flush-to-zero enabled |
| out_valid | output | 1 | A verdict is held |
| out_ready | input | 1 | Consumer takes the verdict |
| out_trap | output | 1 | Trap request |
| out_inv | output | 1 | Invalid-operation exception bit |
| out_swc | output | 1 | Software-completion exception bit |
| out_sticky_inv | output | 1 | Set-sticky-invalid pulse |

## Verification
The classification and rule logic hold no state, so a wrong decision shows on the flags in the cycle right after the operand is taken. That decision can be a misread field boundary, a mode mixed up with another, or an ignored flush control.

The only state is the output register and its valid bit. If that state is wrong, the fault shows at the ports in one of these ways:

- a verdict lingers one cycle too long;
- flags are raised with `out_valid` low;
- a held verdict changes while back-pressure is applied;
- `in_ready` goes high while a verdict is still held.

Each of these appears within one or two cycles of the triggering handshake.

// File: rtl/fpchk_pkg.sv
package fpchk_pkg;

  typedef enum logic [1:0] {
    MODE_PLAIN = 2'd0,
    MODE_CMP   = 2'd1,
    MODE_SWC   = 2'd2,
    MODE_SPARE = 2'd3
  } chk_mode_e;

  typedef struct packed {
    logic trap;
    logic inv;
    logic swc;
    logic sticky;
  } verdict_t;

  localparam verdict_t VERDICT_NONE = '{trap: 1'b0, inv: 1'b0, swc: 1'b0, sticky: 1'b0};

endpackage

// File: rtl/fpchk_classify.sv
module fpchk_classify #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W-1:0] mag,
  output logic                    is_denorm,
  output logic                    is_inf,
  output logic                    is_nan
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_zero, exp_full, frac_nz;

  always_comb begin
    exp_f     = mag[EXP_W+FRAC_W-1:FRAC_W];
    frac_f    = mag[FRAC_W-1:0];
    exp_zero  = (exp_f == '0);
    exp_full  = (exp_f == '1);
    frac_nz   = (frac_f != '0);
    is_denorm = exp_zero && frac_nz;
    is_inf    = exp_full && !frac_nz;
    is_nan    = exp_full && frac_nz;
  end
endmodule

// File: rtl/fpchk_rule.sv
module fpchk_rule
  import fpchk_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int WIDTH = 1 + EXP_W + FRAC_W
) (
  input  logic [WIDTH-1:0] operand,
  input  logic [1:0]       mode,
  input  logic             flush,
  input  logic             is_denorm,
  input  logic             is_inf,
  input  logic             is_nan,
  output verdict_t         verdict
);
  localparam logic [WIDTH-1:0] SUB_MAX  = {{(WIDTH-FRAC_W){1'b0}}, {FRAC_W{1'b1}}};
  localparam logic [WIDTH-1:0] SIGN_BIT = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] magnitude;
  logic             tiny_mag;
  chk_mode_e        m;

  always_comb begin
    // magnitude with the sign cleared; software-completion test is a range compare
    magnitude = operand ^ (operand[WIDTH-1] ? SIGN_BIT : '0);
    tiny_mag  = (magnitude != '0) && (magnitude <= SUB_MAX);
    m         = chk_mode_e'(mode);
    verdict   = VERDICT_NONE;
    unique case (m)
      MODE_CMP: begin
        if (is_denorm) begin
          verdict.trap = 1'b1;
          verdict.inv  = 1'b1;
        end else if (is_nan) begin
          verdict.trap   = 1'b1;
          verdict.inv    = 1'b1;
          verdict.sticky = 1'b1;
        end
      end
      MODE_SWC: begin
        if (tiny_mag && !flush) begin
          verdict.trap = 1'b1;
          verdict.inv  = 1'b1;
          verdict.swc  = 1'b1;
        end
      end
      default: begin
        if (is_denorm) begin
          verdict.trap = 1'b1;
          verdict.inv  = 1'b1;
        end else if (is_inf || is_nan) begin
          verdict.trap   = 1'b1;
          verdict.inv    = 1'b1;
          verdict.sticky = 1'b1;
        end
      end
    endcase
  end
endmodule

// File: rtl/fpchk_stage.sv
module fpchk_stage
  import fpchk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_valid,
  output logic     in_ready,
  input  verdict_t d,
  output logic     out_valid,
  input  logic     out_ready,
  output verdict_t q
);
  logic     vld_q;
  verdict_t hold_q;

  assign in_ready  = !vld_q || out_ready;
  assign out_valid = vld_q;
  assign q         = hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      hold_q <= VERDICT_NONE;
    end else if (in_valid && in_ready) begin
      vld_q  <= 1'b1;
      hold_q <= d;
    end else if (out_ready) begin
      vld_q  <= 1'b0;
      hold_q <= VERDICT_NONE;
    end
  end
endmodule

// File: rtl/fpchk_top.sv
module fpchk_top
  import fpchk_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int WIDTH = 1 + EXP_W + FRAC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  input  logic [1:0]       in_mode,
  input  logic             in_flush,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_trap,
  output logic             out_inv,
  output logic             out_swc,
  output logic             out_sticky_inv
);
  logic     denorm_w, inf_w, nan_w;
  verdict_t verdict_w, held_w;

  fpchk_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_classify (
    .mag       (in_data[WIDTH-2:0]),
    .is_denorm (denorm_w),
    .is_inf    (inf_w),
    .is_nan    (nan_w)
  );

  fpchk_rule #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_rule (
    .operand   (in_data),
    .mode      (in_mode),
    .flush     (in_flush),
    .is_denorm (denorm_w),
    .is_inf    (inf_w),
    .is_nan    (nan_w),
    .verdict   (verdict_w)
  );

  fpchk_stage u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .d         (verdict_w),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .q         (held_w)
  );

  assign out_trap       = held_w.trap;
  assign out_inv        = held_w.inv;
  assign out_swc        = held_w.swc;
  assign out_sticky_inv = held_w.sticky;
endmodule

// File: rtl/fpchk_sva.sv
module fpchk_sva #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int WIDTH = 1 + EXP_W + FRAC_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [WIDTH-1:0] in_data,
  input logic [1:0]       in_mode,
  input logic             in_flush,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_trap,
  input logic             out_inv,
  input logic             out_swc,
  input logic             out_sticky_inv
);
  logic [3:0] flags;
  logic       take, exp_full, frac_zero;
  assign flags     = {out_trap, out_inv, out_swc, out_sticky_inv};
  assign take      = in_valid && in_ready;
  assign exp_full  = (in_data[WIDTH-2:FRAC_W] == '1);
  assign frac_zero = (in_data[FRAC_W-1:0] == '0);

  a_r8_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (flags == 4'b0000));

  a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(flags)));

  a_r9_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r4_swc_implies_trap: assert property (@(posedge clk) disable iff (!rst_n)
    out_swc |-> (out_trap && out_inv && !out_sticky_inv));

  a_r2_sticky_implies_trap: assert property (@(posedge clk) disable iff (!rst_n)
    out_sticky_inv |-> (out_trap && out_inv));

  a_r5_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_mode == 2'd2 && in_flush) |=> !out_trap);

  a_r3_cmp_inf_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_mode == 2'd1 && exp_full && frac_zero) |=> !out_trap);
endmodule

bind fpchk_top fpchk_sva #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_sva (.*);

// File: tb/fpchk_top_tb.sv
`timescale 1ns/1ps
module fpchk_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_data = '0;
  logic [1:0]  in_mode = '0;
  logic        in_flush = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_trap, out_inv, out_swc, out_sticky_inv;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  fpchk_top u_dut (.*);

  // expected {trap, inv, swc, sticky}
  function automatic logic [3:0] model(logic [63:0] v, logic [1:0] md, logic fl);
    logic [10:0] e;
    logic [51:0] f;
    logic [62:0] mg;
    e  = v[62:52];
    f  = v[51:0];
    mg = v[62:0];
    if (md == 2'd2)
      return (mg != 0 && mg <= 63'h000F_FFFF_FFFF_FFFF && !fl) ? 4'b1110 : 4'b0000;
    if (e == 11'd0 && f != 0) return 4'b1100;
    if (e == 11'h7FF) begin
      if (md == 2'd1 && f == 0) return 4'b0000;
      return 4'b1101;
    end
    return 4'b0000;
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] flags();
    return {out_trap, out_inv, out_swc, out_sticky_inv};
  endfunction

  task automatic send(logic [63:0] v, logic [1:0] md, logic fl, string tag);
    logic [3:0] e;
    e = model(v, md, fl);
    @(negedge clk);
    in_valid = 1'b1; in_data = v; in_mode = md; in_flush = fl;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1, {tag, " valid"}, {63'd0, out_valid}, 64'd1);
    check(flags() === e, tag, {60'd0, flags()}, {60'd0, e});
  endtask

  function automatic logic [63:0] rnd_op();
    logic [63:0] v;
    int k;
    v = {$urandom, $urandom};
    k = $urandom_range(0, 5);
    case (k)
      0: v[62:52] = 11'd0;
      1: v[62:52] = 11'h7FF;
      2: begin v[62:52] = 11'h7FF; v[51:0] = '0; end
      3: v[62:0] = '0;
      4: begin v[62:52] = 11'd0; v[51:0] = 52'd1 << $urandom_range(0, 51); end
      default: ;
    endcase
    return v;
  endfunction

  initial begin
    #(8 * 20000);
    check(1'b0, "watchdog", 64'd0, 64'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // reset state
    check(out_valid === 1'b0 && flags() === 4'b0, "R8 reset", {59'd0, out_valid, flags()}, 64'd0);
    check(in_ready === 1'b1, "R9 reset ready", {63'd0, in_ready}, 64'd1);
    rst_n = 1'b1;

    send(64'h0000_0000_0000_0001, 2'd0, 1'b0, "R1 plain denorm");
    send(64'h800F_FFFF_FFFF_FFFF, 2'd0, 1'b0, "R1 plain neg denorm");
    send(64'h7FF0_0000_0000_0000, 2'd0, 1'b0, "R2 plain inf");
    send(64'hFFF8_0000_0000_0000, 2'd0, 1'b0, "R2 plain nan");
    send(64'h7FF0_0000_0000_0000, 2'd1, 1'b0, "R3 cmp inf");
    send(64'hFFF0_0000_0000_0000, 2'd1, 1'b0, "R3 cmp neg inf");
    send(64'h7FF0_0000_0000_0001, 2'd1, 1'b0, "R3 cmp nan");
    send(64'h0000_0000_0000_0010, 2'd1, 1'b0, "R3 cmp denorm");
    send(64'h000F_FFFF_FFFF_FFFF, 2'd2, 1'b0, "R4 swc max denorm");
    send(64'h8000_0000_0000_0001, 2'd2, 1'b0, "R4 swc neg denorm");
    send(64'h0010_0000_0000_0000, 2'd2, 1'b0, "R6 swc smallest normal");
    send(64'h0000_0000_0000_0001, 2'd2, 1'b1, "R5 swc flushed");
    send(64'h7FF8_0000_0000_0000, 2'd2, 1'b0, "R5 swc nan");
    send(64'hFFF0_0000_0000_0000, 2'd2, 1'b0, "R5 swc inf");
    send(64'h0000_0000_0000_0000, 2'd0, 1'b0, "R6 pos zero");
    send(64'h8000_0000_0000_0000, 2'd1, 1'b0, "R6 neg zero");
    send(64'h8000_0000_0000_0000, 2'd2, 1'b0, "R6 swc neg zero");
    send(64'h3FF0_0000_0000_0000, 2'd0, 1'b0, "R6 one");
    send(64'h7FE0_0000_0000_0000, 2'd0, 1'b0, "R6 max exp normal");
    send(64'h7FF0_0000_0000_0000, 2'd3, 1'b0, "R7 spare inf");
    send(64'h0000_0000_0000_0002, 2'd3, 1'b1, "R7 spare denorm");
    send(64'h0000_0000_0000_0002, 2'd0, 1'b1, "R10 plain denorm flush");
    send(64'h7FF0_0000_0000_0000, 2'd1, 1'b1, "R10 cmp inf flush");

    // R8 return to idle
    @(negedge clk);
    check(out_valid === 1'b0 && flags() === 4'b0, "R8 idle", {59'd0, out_valid, flags()}, 64'd0);

    // R9 back-pressure
    out_ready = 1'b0;
    in_valid = 1'b1; in_data = 64'h7FF0_0000_0000_0000; in_mode = 2'd0; in_flush = 1'b0;
    @(negedge clk);
    in_data = 64'h0000_0000_0000_0000;
    check(in_ready === 1'b0, "R9 not ready", {63'd0, in_ready}, 64'd0);
    repeat (2) @(negedge clk);
    check(out_valid === 1'b1 && flags() === 4'b1101, "R9 held", {59'd0, out_valid, flags()}, 64'h1D);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1 && flags() === 4'b0000, "R9 next taken", {59'd0, out_valid, flags()}, 64'h10);
    @(negedge clk);
    check(out_valid === 1'b0, "R8 drained", {63'd0, out_valid}, 64'd0);

    // random stimulus
    for (int i = 0; i < 400; i++) begin
      logic [63:0] v;
      logic [1:0]  md;
      logic        fl;
      v  = rnd_op();
      md = 2'($urandom_range(0, 3));
      fl = 1'($urandom_range(0, 1));
      send(v, md, fl, (md == 2'd2) ? "R4 R5 random swc" : "R1 R2 R3 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule